// File: doc/BRIEF.md
# Rate One-Third Trellis Symbol Encoder

This block turns a stream of 5-bit data words into 7-bit trellis-coded symbols, one word per clock. The lowest bit of each accepted word enters a five-stage shift register. Three parity bits are formed from fixed XOR taps on that register. The four upper data bits travel alongside without coding and fill the top of the symbol. Mapping the symbol onto a constellation is left to a later stage.

A word is accepted on a rising edge where `in_valid` is high. The symbol it produces appears on the following cycle with `out_valid` high. A two-state controller tracks whether the output register holds a fresh symbol.

- `ST_IDLE` means no fresh symbol.
- `ST_EMIT` means a symbol was just produced.

The controller has four transitions:
- `T_ACCEPT`: from `ST_IDLE` to `ST_EMIT` on `in_valid`.
- `T_STREAM`: from `ST_EMIT` to `ST_EMIT` on `in_valid`.
- `T_DRAIN`: from `ST_EMIT` to `ST_IDLE` when `in_valid` is low.
- `T_WAIT`: from `ST_IDLE` to `ST_IDLE` when `in_valid` is low.

Reset forces `ST_IDLE` from either state.

Top module: `tcm_sym_enc`

## Requirements
- R1: While `rst` is high at a rising edge, the shift register is cleared to zero, `out_valid` goes low and `out_sym` goes to zero. Reset takes priority over `in_valid`.
- R2: On an edge with `in_valid` high and no reset, `in_word[0]` becomes stage X0 (the newest bit). Each stage Xi moves to Xi+1, and X4 is dropped.
- R3: `out_sym[0]` equals X0 xor X1, taken from the register contents after that shift.
- R4: `out_sym[1]` equals X1 xor X2 xor X3, taken after the shift.
- R5: `out_sym[2]` equals X0 xor X2 xor X3, taken after the shift.
- R6: `out_sym[6:3]` equals `in_word[4:1]` of the accepted word, with bit order unchanged.
- R7: `out_valid` is high exactly one cycle after an edge where `in_valid` was high and reset was low.
- R8: On an edge with `in_valid` low, the shift register keeps its value. `out_valid` is then low and `out_sym` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Data word strobe |
| in_word | input | 5 | Data word; bit 0 is coded, bits 4:1 are uncoded |
| out_valid | output | 1 | Symbol strobe, one cycle after acceptance |
| out_sym | output | 7 | Coded symbol; bits 2:0 are parity, bits 6:3 are uncoded |

## Verification
Two events can fall on the same edge: a reset, and a word accepted mid-stream with `in_valid` high. The bench asserts `rst` while words are still streaming. It then expects a cleared register, a low `out_valid` and a zero symbol, and it expects the accepted word to be discarded. The next words must then be coded as if the register had started from zero, and a scoreboard model predicts every output field.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    localparam int K_LEN   = 5;
    localparam int UNC_W   = 4;
    localparam int COD_W   = 3;
    localparam int IN_W    = UNC_W + 1;
    localparam int SYM_W   = UNC_W + COD_W;
    // tap masks, bit i selects stage Xi
    localparam logic [COD_W*K_LEN-1:0] TAPS = {5'b01101, 5'b01110, 5'b00011};

    typedef enum logic {ST_IDLE = 1'b0, ST_EMIT = 1'b1} emit_state_t;
endpackage

// File: rtl/tcm_shift_reg.sv
module tcm_shift_reg
    import tcm_pkg::*;
#(
    parameter int DEPTH = K_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [DEPTH-1:0] stages,
    output logic [DEPTH-1:0] stages_next
);
    assign stages_next = {stages[DEPTH-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst)
            stages <= '0;
        else if (shift_en)
            stages <= stages_next;
    end

    // R2: older stages move up by one on a shift
    a_r2_shift: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stages[DEPTH-1:1] == $past(stages[DEPTH-2:0]));
    // R2: newest stage takes the coded input bit
    a_r2_newest: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stages[0] == $past(bit_in));
    // R8: no shift, no change
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(stages));
endmodule

// File: rtl/tcm_parity.sv
module tcm_parity
    import tcm_pkg::*;
#(
    parameter int DEPTH = K_LEN,
    parameter int NOUT  = COD_W,
    parameter logic [NOUT*DEPTH-1:0] MASKS = TAPS
) (
    input  logic [DEPTH-1:0] stages,
    output logic [NOUT-1:0]  parity
);
    for (genvar g = 0; g < NOUT; g++) begin : g_tap
        assign parity[g] = ^(stages & MASKS[g*DEPTH +: DEPTH]);
    end
endmodule

// File: rtl/tcm_sym_enc.sv
module tcm_sym_enc
    import tcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_word,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym
);
    emit_state_t state, state_nx;
    logic [K_LEN-1:0] sr, sr_nx;
    logic [COD_W-1:0] par_nx;

    tcm_shift_reg #(.DEPTH(K_LEN)) u_sr (
        .clk(clk), .rst(rst), .shift_en(in_valid), .bit_in(in_word[0]),
        .stages(sr), .stages_next(sr_nx)
    );

    tcm_parity #(.DEPTH(K_LEN), .NOUT(COD_W), .MASKS(TAPS)) u_par (
        .stages(sr_nx), .parity(par_nx)
    );

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE; // T_ACCEPT / T_WAIT
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE; // T_STREAM / T_DRAIN
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_sym <= '0;
        else if (in_valid)
            out_sym <= {in_word[IN_W-1:1], par_nx};
    end

    assign out_valid = (state == ST_EMIT);

    // R7: accepted word yields a strobe next cycle
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R8: no word, no strobe, symbol held
    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(out_sym));
    // R6: uncoded bits pass unchanged
    a_r6_uncoded: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_sym[SYM_W-1:COD_W] == $past(in_word[IN_W-1:1]));
    // R3: first parity bit from the two newest stages
    a_r3_par0: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_sym[0] == (sr[0] ^ sr[1]));
endmodule

// File: tb/test_tcm_sym_enc.sv
module test_tcm_sym_enc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [4:0] in_word = '0;
    logic       out_valid;
    logic [6:0] out_sym;

    int n_chk = 0;
    int n_err = 0;

    typedef struct packed {
        logic       was_rst;
        logic       vld;
        logic [6:0] sym;
    } exp_t;
    exp_t q[$];

    logic [4:0] m_sr  = '0;
    logic [6:0] m_sym = '0;

    always #2 clk = ~clk;

    tcm_sym_enc i_tcm_sym_enc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_sym(out_sym)
    );

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and predicts the result
    task automatic drive(input logic r, input logic v, input logic [4:0] w);
        exp_t e;
        @(negedge clk);
        rst = r; in_valid = v; in_word = w;
        if (r) begin
            m_sr = '0; m_sym = '0; e.vld = 1'b0;
        end else if (v) begin
            m_sr = {m_sr[3:0], w[0]};                     // R2
            m_sym = {w[4:1],
                     m_sr[0] ^ m_sr[2] ^ m_sr[3],          // R5
                     m_sr[1] ^ m_sr[2] ^ m_sr[3],          // R4
                     m_sr[0] ^ m_sr[1]};                   // R3
            e.vld = 1'b1;
        end else begin
            e.vld = 1'b0;
        end
        e.was_rst = r;
        e.sym = m_sym;
        q.push_back(e);
    endtask

    // monitor: compares each cycle's result
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.was_rst) begin
                chk("R1 valid", {6'b0, out_valid}, 7'b0);
                chk("R1 symbol", out_sym, 7'b0);
            end else begin
                chk(e.vld ? "R7 valid" : "R8 valid", {6'b0, out_valid}, {6'b0, e.vld});
                chk("R3 (R2 shift) y0", {6'b0, out_sym[0]}, {6'b0, e.sym[0]});
                chk("R4 (R2 shift) y1", {6'b0, out_sym[1]}, {6'b0, e.sym[1]});
                chk("R5 (R2 shift) y2", {6'b0, out_sym[2]}, {6'b0, e.sym[2]});
                chk(e.vld ? "R6 uncoded" : "R8 hold", {3'b0, out_sym[6:3]}, {3'b0, e.sym[6:3]});
            end
        end
    end

    initial begin
        fork
            begin
                drive(1, 0, 5'h00);
                drive(1, 1, 5'h1F);
                // impulse response of the coded bit
                drive(0, 1, 5'b00001);
                for (int i = 0; i < 5; i++) drive(0, 1, 5'b10100);
                // all ones, then gaps
                for (int i = 0; i < 6; i++) drive(0, 1, 5'h1F);
                drive(0, 0, 5'h15);
                drive(0, 0, 5'h0A);
                drive(0, 1, 5'h0E);
                // random stream with idle gaps
                for (int i = 0; i < 300; i++) drive(0, ($urandom % 4) != 0, 5'($urandom));
                // R1: reset while a word is offered mid-stream
                drive(1, 1, 5'h1B);
                drive(0, 1, 5'h01);
                drive(0, 1, 5'h00);
                for (int i = 0; i < 200; i++) drive(0, ($urandom % 3) != 0, 5'($urandom));
                drive(0, 0, 5'h00);
                drive(0, 0, 5'h00);
                @(negedge clk);
                @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule